// File: doc/BRIEF.md
# Interrupt and Exception Entry Sequencer

This block sits beside the instruction sequencer of a processor core and, once at each instruction boundary, makes the entry decision: take a machine check, take a program check, take a pending external interrupt, or carry on. When an entry is taken, it produces the following one cycle after the boundary:

- the vector number;
- the address of the program status pair for that vector;
- the instruction address that goes into the old status;
- the updated check-status word.

For checks it also raises an exception indication. The sequencer uses that indication to force its branch state to an exception state, which stops a multi-word load or store before its next transfer.

The block holds a one-shot deferral flag. The flag keeps external interrupts out for exactly one boundary in two cases: after a load-program-status instruction that has its defer opcode bit set, and when a branch-with-execute hands over to its subject instruction. No interrupt can therefore fall between a delayed branch and its subject.

When a check is raised by the subject of an execute-form branch, the saved address is that of the branch, not that of the subject. A subject that is itself an execute-form branch, trap or wait is illegal and raises a program check.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `take_o`, `exc_o` and `defer_o` are all 0 after that edge.
- R2: `take_o` is a single-cycle pulse. It is high only in the cycle after a clock edge at which `step_i` was high and an entry was chosen. `vector_o`, `pair_addr_o`, `old_addr_o` and `chk_stat_o` are valid in that cycle. Without a boundary, `take_o` stays 0.
- R3: An external interrupt is not taken in any of these cases: `irq_mask_i` is 1, `chk_stat_i` is nonzero, or no bit of `irq_req_i` is set.
- R4: Among the pending requests, the lowest-numbered level wins, and its level number is the vector. It is taken only if that level is numerically lower than `cur_prio_i`.
- R5: `defer_o` is set by a boundary at which `lps_i` is 1 and bit 4 of `lps_opc_i` is 1. While set, it blocks external interrupts at the next boundary and is then cleared by that boundary, unless that boundary sets it again.
- R6: A boundary with `br_state_i` = 1 (delay state; encodings: 0 normal, 1 delay, 2 executing subject, 3 wait) sets `defer_o`.
- R7: A machine check (`mchk_i`) enters at vector 7 and takes precedence over everything else. Its new status is `chk_stat_i` ORed with `mchk_cause_i & 16'hBE00`, and its old address is `cur_addr_i`. A program check enters at vector 8 and takes precedence over external interrupts.
- R8: `pair_addr_o` equals 32'h100 + 16 × `vector_o`.
- R9: For a program check, `chk_stat_o` = (`chk_stat_i` & ~16'h00FE) | (cause & 16'h00FE). The bits outside 16'h00FE are kept unchanged.
- R10: For a program check at a boundary with `br_state_i` = 2, `old_addr_o` is `br_addr_i`. At any other boundary it is `cur_addr_i`. For an external interrupt it is always `cur_addr_i`.
- R11: `subj_xform_i` = 1 at a boundary with `br_state_i` = 2 raises a program check with cause 16'h0084. The cause is ORed with `pchk_cause_i` when `pchk_i` is also 1. With any other branch state, `subj_xform_i` has no effect.
- R12: `exc_o` pulses together with `take_o` for machine and program checks, and stays 0 for external interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Instruction boundary strobe |
| irq_req_i | input | NUM_LEVELS | Pending interrupt levels, bit 0 is highest priority |
| irq_mask_i | input | 1 | Interrupt mask bit |
| cur_prio_i | input | LVL_W | Current priority field |
| chk_stat_i | input | 16 | Current machine/program-check status word |
| mchk_i | input | 1 | Machine check raised at this boundary |
| mchk_cause_i | input | 16 | Machine-check cause bits |
| pchk_i | input | 1 | Program check raised at this boundary |
| pchk_cause_i | input | 16 | Program-check cause bits |
| br_state_i | input | 2 | Branch state of the sequencer |
| cur_addr_i | input | ADDR_W | Current instruction address |
| br_addr_i | input | ADDR_W | Address of the execute-form branch |
| lps_i | input | 1 | Load-program-status executed at this boundary |
| lps_opc_i | input | OPC_W | Opcode of that instruction |
| subj_xform_i | input | 1 | Current instruction is an execute-form branch, trap or wait |
| take_o | output | 1 | Entry taken (one-cycle pulse) |
| vector_o | output | 4 | Vector number |
| pair_addr_o | output | ADDR_W | Program status pair address |
| old_addr_o | output | ADDR_W | Address to save as old status |
| chk_stat_o | output | 16 | New check-status word |
| exc_o | output | 1 | Check taken: abort multi-transfer |
| defer_o | output | 1 | Deferral flag |

## Verification
The bench looks for the cases where gating and ordering interact. It pairs a defer-setting boundary with a pending request, and runs a second boundary right after it. A flag that does not clear would block interrupts forever, and one that is never set would let the interrupt split a branch from its subject. A pending level equal to the current priority must be refused; an off-by-one compare would take it. A check in the subject slot must save the branch address; a design that saves the current address would resume the wrong instruction. Machine and program checks raised together must give vector 7, and status bits outside the program-check field must survive a program check.

// File: rtl/irq_entry_pkg.sv
// Package: shared constants and types of the interrupt entry sequencer.
// Assumes a 16-bit check-status word with machine-check bits in the upper
// byte and program-check bits in the lower byte.
package irq_entry_pkg;

    localparam int STAT_W = 16;
    localparam int VEC_W  = 4;

    // Writable field of the program-check causes and of the machine-check causes.
    localparam logic [STAT_W-1:0] PCHK_FIELD    = 16'h00FE;
    localparam logic [STAT_W-1:0] MCHK_FIELD    = 16'hBE00;
    // Cause bits for an illegal subject of an execute-form branch.
    localparam logic [STAT_W-1:0] ILLEGAL_CAUSE = 16'h0084;

    localparam logic [VEC_W-1:0] MCHK_VEC = 4'd7;
    localparam logic [VEC_W-1:0] PCHK_VEC = 4'd8;

    typedef enum logic [1:0] {
        BR_NONE    = 2'd0,
        BR_DELAY   = 2'd1,
        BR_SUBJECT = 2'd2,
        BR_WAIT    = 2'd3
    } br_state_e;

    typedef struct packed {
        logic              take;
        logic              exc;
        logic [VEC_W-1:0]  vec;
        logic [STAT_W-1:0] stat;
    } entry_t;

endpackage

// File: rtl/irq_level_pick.sv
// Module: picks the highest-priority (lowest-numbered) pending request level
// and reports whether it beats the current priority field.
// Assumes NUM_LEVELS fits in LVL_W bits.
module irq_level_pick #(
    parameter int NUM_LEVELS = 7,
    parameter int LVL_W      = 3
) (
    input  logic [NUM_LEVELS-1:0] req_i,
    input  logic [LVL_W-1:0]      prio_i,
    output logic                  pend_o,
    output logic [LVL_W-1:0]      level_o,
    output logic                  eligible_o
);

    logic [NUM_LEVELS:0]   seen;
    logic [NUM_LEVELS-1:0] first;

    assign seen[0] = 1'b0;

    // Ripple chain: a level is first when no lower-numbered level is pending.
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_chain
        assign first[g]    = req_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | req_i[g];
    end

    // Encode the one-hot winner into a level number.
    always_comb begin
        level_o = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (first[i]) level_o = level_o | LVL_W'(i);
        end
    end

    assign pend_o     = seen[NUM_LEVELS];
    assign eligible_o = pend_o && (level_o < prio_i);

endmodule

// File: rtl/irq_defer_ctl.sv
// Module: one-shot interrupt deferral flag.
// Each boundary consumes the flag and reloads it from this boundary's set
// conditions (load-status with defer bit, or delay state of an execute branch).
module irq_defer_ctl
    import irq_entry_pkg::*;
#(
    parameter int OPC_W     = 8,
    parameter int DEFER_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             lps_i,
    input  logic [OPC_W-1:0] lps_opc_i,
    input  br_state_e        br_state_i,
    output logic             defer_q
);

    logic set_req;

    // Set condition seen at this boundary.
    assign set_req = (lps_i && lps_opc_i[DEFER_BIT]) || (br_state_i == BR_DELAY);

    // Flag register: reloaded at every boundary, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      defer_q <= 1'b0;
        else if (step_i) defer_q <= set_req;
    end

    AST_DEFER_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && defer_q && !set_req) |=> !defer_q); // R5
    AST_DEFER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && br_state_i == BR_DELAY) |=> defer_q); // R6

endmodule

// File: rtl/irq_entry_calc.sv
// Module: combinational entry decision at a boundary.
// Order: machine check, then program check (explicit or illegal subject),
// then an external interrupt already qualified by the caller.
module irq_entry_calc
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LVL_W  = 3
) (
    input  logic              mchk_i,
    input  logic [STAT_W-1:0] mchk_cause_i,
    input  logic              pchk_i,
    input  logic [STAT_W-1:0] pchk_cause_i,
    input  logic              subj_xform_i,
    input  br_state_e         br_state_i,
    input  logic [STAT_W-1:0] chk_stat_i,
    input  logic              irq_ok_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [ADDR_W-1:0] br_addr_i,
    output entry_t            ent_o,
    output logic [ADDR_W-1:0] old_addr_o
);

    logic              in_subject;
    logic              illegal;
    logic [STAT_W-1:0] pcause;

    // Illegal subject detection and merged program-check cause.
    always_comb begin
        in_subject = (br_state_i == BR_SUBJECT);
        illegal    = in_subject && subj_xform_i;
        pcause     = (pchk_i ? pchk_cause_i : '0) | (illegal ? ILLEGAL_CAUSE : '0);
    end

    // Prioritised choice of entry, new status and saved address.
    always_comb begin
        ent_o      = '0;
        ent_o.stat = chk_stat_i;
        old_addr_o = cur_addr_i;
        if (mchk_i) begin
            ent_o.take = 1'b1;
            ent_o.exc  = 1'b1;
            ent_o.vec  = MCHK_VEC;
            ent_o.stat = chk_stat_i | (mchk_cause_i & MCHK_FIELD);
        end else if (pchk_i || illegal) begin
            ent_o.take = 1'b1;
            ent_o.exc  = 1'b1;
            ent_o.vec  = PCHK_VEC;
            ent_o.stat = (chk_stat_i & ~PCHK_FIELD) | (pcause & PCHK_FIELD);
            old_addr_o = in_subject ? br_addr_i : cur_addr_i;
        end else if (irq_ok_i) begin
            ent_o.take = 1'b1;
            ent_o.vec  = VEC_W'(level_i);
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Module: interrupt and exception entry sequencer (top).
// Evaluates one entry per step_i boundary and registers the result, so all
// outputs are valid one cycle after the boundary. Assumes NUM_LEVELS <= 7 so
// that interrupt vectors never collide with the check vectors 7 and 8.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NUM_LEVELS   = 7,
    parameter int ADDR_W       = 32,
    parameter int OPC_W        = 8,
    parameter int DEFER_BIT    = 4,
    parameter logic [ADDR_W-1:0] PAIR_BASE = 32'h0000_0100,
    parameter int STRIDE_LOG2  = 4,
    localparam int LVL_W       = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  logic [NUM_LEVELS-1:0] irq_req_i,
    input  logic                  irq_mask_i,
    input  logic [LVL_W-1:0]      cur_prio_i,
    input  logic [15:0]           chk_stat_i,
    input  logic                  mchk_i,
    input  logic [15:0]           mchk_cause_i,
    input  logic                  pchk_i,
    input  logic [15:0]           pchk_cause_i,
    input  logic [1:0]            br_state_i,
    input  logic [ADDR_W-1:0]     cur_addr_i,
    input  logic [ADDR_W-1:0]     br_addr_i,
    input  logic                  lps_i,
    input  logic [OPC_W-1:0]      lps_opc_i,
    input  logic                  subj_xform_i,
    output logic                  take_o,
    output logic [3:0]            vector_o,
    output logic [ADDR_W-1:0]     pair_addr_o,
    output logic [ADDR_W-1:0]     old_addr_o,
    output logic [15:0]           chk_stat_o,
    output logic                  exc_o,
    output logic                  defer_o
);

    br_state_e         br_state;
    logic              pend;
    logic [LVL_W-1:0]  level;
    logic              eligible;
    logic              defer_q;
    logic              irq_ok;
    entry_t            ent;
    logic [ADDR_W-1:0] old_addr_n;
    logic [ADDR_W-1:0] pair_addr_n;

    assign br_state = br_state_e'(br_state_i);

    irq_level_pick #(
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W)
    ) u_pick (
        .req_i      (irq_req_i),
        .prio_i     (cur_prio_i),
        .pend_o     (pend),
        .level_o    (level),
        .eligible_o (eligible)
    );

    irq_defer_ctl #(
        .OPC_W     (OPC_W),
        .DEFER_BIT (DEFER_BIT)
    ) u_defer (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step_i),
        .lps_i      (lps_i),
        .lps_opc_i  (lps_opc_i),
        .br_state_i (br_state),
        .defer_q    (defer_q)
    );

    // External interrupt gate: unmasked, no check pending, not deferred.
    assign irq_ok = pend && eligible && !irq_mask_i && (chk_stat_i == '0) && !defer_q;

    irq_entry_calc #(
        .ADDR_W (ADDR_W),
        .LVL_W  (LVL_W)
    ) u_calc (
        .mchk_i       (mchk_i),
        .mchk_cause_i (mchk_cause_i),
        .pchk_i       (pchk_i),
        .pchk_cause_i (pchk_cause_i),
        .subj_xform_i (subj_xform_i),
        .br_state_i   (br_state),
        .chk_stat_i   (chk_stat_i),
        .irq_ok_i     (irq_ok),
        .level_i      (level),
        .cur_addr_i   (cur_addr_i),
        .br_addr_i    (br_addr_i),
        .ent_o        (ent),
        .old_addr_o   (old_addr_n)
    );

    // Status-pair address for the chosen vector.
    assign pair_addr_n = PAIR_BASE + (ADDR_W'(ent.vec) << STRIDE_LOG2);

    // Output register: strobes pulse for one cycle, payload held on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o      <= 1'b0;
            exc_o       <= 1'b0;
            vector_o    <= '0;
            pair_addr_o <= '0;
            old_addr_o  <= '0;
            chk_stat_o  <= '0;
        end else begin
            take_o <= step_i && ent.take;
            exc_o  <= step_i && ent.exc;
            if (step_i && ent.take) begin
                vector_o    <= ent.vec;
                pair_addr_o <= pair_addr_n;
                old_addr_o  <= old_addr_n;
                chk_stat_o  <= ent.stat;
            end
        end
    end

    assign defer_o = defer_q;

    AST_TAKE_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(step_i)); // R2
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !exc_o) |-> $past(!irq_mask_i && chk_stat_i == '0 && irq_req_i != '0)); // R3
    AST_IRQ_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !exc_o) |-> (int'(vector_o) < int'($past(cur_prio_i)))); // R4
    AST_IRQ_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !exc_o) |-> !$past(defer_q)); // R5
    AST_MCHK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(mchk_i)) |-> (vector_o == MCHK_VEC)); // R7
    AST_PAIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (pair_addr_o[STRIDE_LOG2-1:0] == '0 && (pair_addr_o - PAIR_BASE) >> STRIDE_LOG2 == ADDR_W'(vector_o))); // R8
    AST_PCHK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o == PCHK_VEC) |-> (((chk_stat_o ^ $past(chk_stat_i)) & ~PCHK_FIELD) == '0)); // R9
    AST_OLD_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && vector_o == PCHK_VEC && $past(br_state_i) == 2'd2) |-> (old_addr_o == $past(br_addr_i))); // R10
    AST_ILLEGAL_SUBJ: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && br_state == BR_SUBJECT && subj_xform_i && !mchk_i) |=> (take_o && vector_o == PCHK_VEC)); // R11
    AST_EXC_ONLY_CHECKS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (take_o && (vector_o == MCHK_VEC || vector_o == PCHK_VEC))); // R12

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

    localparam int NL = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [NL-1:0] irq_req_i = '0;
    logic        irq_mask_i = 1'b0;
    logic [2:0]  cur_prio_i = '0;
    logic [15:0] chk_stat_i = '0;
    logic        mchk_i = 1'b0;
    logic [15:0] mchk_cause_i = '0;
    logic        pchk_i = 1'b0;
    logic [15:0] pchk_cause_i = '0;
    logic [1:0]  br_state_i = '0;
    logic [31:0] cur_addr_i = '0;
    logic [31:0] br_addr_i = '0;
    logic        lps_i = 1'b0;
    logic [7:0]  lps_opc_i = '0;
    logic        subj_xform_i = 1'b0;
    logic        take_o;
    logic [3:0]  vector_o;
    logic [31:0] pair_addr_o;
    logic [31:0] old_addr_o;
    logic [15:0] chk_stat_o;
    logic        exc_o;
    logic        defer_o;

    irq_entry_seq dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic        take;
        logic        exc;
        logic        defer;
        logic [3:0]  vec;
        logic [31:0] pair;
        logic [31:0] old;
        logic [15:0] stat;
        logic        chk_stat;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    logic m_defer = 1'b0;

    // Staging values copied onto the pins by fire().
    logic [NL-1:0] s_req;
    logic        s_mask;
    logic [2:0]  s_prio;
    logic [15:0] s_stat;
    logic        s_mchk;
    logic [15:0] s_mc;
    logic        s_pchk;
    logic [15:0] s_pc;
    logic [1:0]  s_br;
    logic [31:0] s_cur;
    logic [31:0] s_bra;
    logic        s_lps;
    logic [7:0]  s_op;
    logic        s_xf;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        s_req = '0; s_mask = 0; s_prio = 3'd7; s_stat = '0; s_mchk = 0; s_mc = '0;
        s_pchk = 0; s_pc = '0; s_br = 2'd0; s_cur = 32'h0000_4000; s_bra = 32'h0000_3FF0;
        s_lps = 0; s_op = '0; s_xf = 0;
    endtask

    // Driver: puts one boundary on the pins and queues the expected result.
    task automatic fire(input string tag);
        exp_t e;
        int   lvl;
        logic ill;
        logic [15:0] cause;
        @(negedge clk);
        step_i = 1; irq_req_i = s_req; irq_mask_i = s_mask; cur_prio_i = s_prio;
        chk_stat_i = s_stat; mchk_i = s_mchk; mchk_cause_i = s_mc; pchk_i = s_pchk;
        pchk_cause_i = s_pc; br_state_i = s_br; cur_addr_i = s_cur; br_addr_i = s_bra;
        lps_i = s_lps; lps_opc_i = s_op; subj_xform_i = s_xf;
        lvl = -1;
        for (int i = NL - 1; i >= 0; i--) if (s_req[i]) lvl = i;
        ill = (s_br == 2'd2) && s_xf;
        e.tag = tag; e.take = 0; e.exc = 0; e.vec = 0; e.old = s_cur; e.stat = s_stat;
        e.chk_stat = 0;
        if (s_mchk) begin
            e.take = 1; e.exc = 1; e.vec = 4'd7; e.stat = s_stat | (s_mc & 16'hBE00);
            e.chk_stat = 1;
        end else if (s_pchk || ill) begin
            cause = (s_pchk ? s_pc : 16'h0) | (ill ? 16'h0084 : 16'h0);
            e.take = 1; e.exc = 1; e.vec = 4'd8; e.chk_stat = 1;
            e.stat = (s_stat & ~16'h00FE) | (cause & 16'h00FE);
            e.old = (s_br == 2'd2) ? s_bra : s_cur;
        end else if (!s_mask && s_stat == 0 && lvl >= 0 && lvl < int'(s_prio) && !m_defer) begin
            e.take = 1; e.vec = 4'(lvl);
        end
        e.pair = 32'h100 + 32'(e.vec) * 16;
        m_defer = (s_lps && s_op[4]) || (s_br == 2'd1);
        e.defer = m_defer;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        step_i = 0; irq_req_i = '0; mchk_i = 0; pchk_i = 0; subj_xform_i = 0; lps_i = 0;
        br_state_i = 0; chk_stat_i = '0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pops one expected item per boundary, otherwise checks quiet outputs.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(take_o == e.take, e.tag, "take", 32'(take_o), 32'(e.take));
                check(exc_o == e.exc, e.tag, "exc", 32'(exc_o), 32'(e.exc));
                check(defer_o == e.defer, e.tag, "defer", 32'(defer_o), 32'(e.defer));
                if (e.take) begin
                    check(vector_o == e.vec, e.tag, "vector", 32'(vector_o), 32'(e.vec));
                    check(pair_addr_o == e.pair, {e.tag, "/R8"}, "pair", pair_addr_o, e.pair);
                    check(old_addr_o == e.old, e.tag, "old", old_addr_o, e.old);
                    if (e.chk_stat)
                        check(chk_stat_o == e.stat, e.tag, "stat", 32'(chk_stat_o), 32'(e.stat));
                end
            end else begin
                check(take_o == 0 && exc_o == 0, "R2", "quiet", 32'(take_o), 32'h0);
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(take_o == 0, "R1", "take", 32'(take_o), 0);
        check(exc_o == 0, "R1", "exc", 32'(exc_o), 0);
        check(defer_o == 0, "R1", "defer", 32'(defer_o), 0);
        rst_n = 1;
        idle(2);

        // R4: single request taken, R8 pair address
        clr(); s_req = 7'b0001000; fire("R4");
        // R4: lowest level wins among several
        clr(); s_req = 7'b0100100; s_cur = 32'h0000_8888; fire("R4");
        // R4: level equal to priority refused, one lower accepted
        clr(); s_req = 7'b0000100; s_prio = 3'd2; fire("R4");
        clr(); s_req = 7'b0000100; s_prio = 3'd3; fire("R4");
        idle(2);
        // R3: mask, nonzero status, no request
        clr(); s_req = 7'b0000001; s_mask = 1; fire("R3");
        clr(); s_req = 7'b0000001; s_stat = 16'h0200; fire("R3");
        clr(); fire("R3");
        idle(1);
        // R5: defer after load-status with bit 4, consumed by one boundary
        clr(); s_lps = 1; s_op = 8'h10; fire("R5");
        clr(); s_req = 7'b0000010; fire("R5");
        clr(); s_req = 7'b0000010; fire("R5");
        // R5: bit 4 clear sets no defer
        clr(); s_lps = 1; s_op = 8'hEF; fire("R5");
        clr(); s_req = 7'b0000010; fire("R5");
        idle(3);
        // R6: delay state defers the subject boundary
        clr(); s_br = 2'd1; fire("R6");
        clr(); s_br = 2'd2; s_req = 7'b0000001; fire("R6");
        clr(); s_req = 7'b0000001; fire("R6");
        idle(1);
        // R7/R12: machine check over interrupt and program check
        clr(); s_mchk = 1; s_mc = 16'hFFFF; s_stat = 16'h0011; s_req = 7'b1; fire("R7");
        clr(); s_mchk = 1; s_mc = 16'h8000; s_pchk = 1; s_pc = 16'h0002; fire("R7");
        // R9: program check field replace, other bits kept
        clr(); s_pchk = 1; s_pc = 16'hFF08; s_stat = 16'h12F3; s_req = 7'b1; fire("R9");
        // R10: program check in subject saves branch address
        clr(); s_pchk = 1; s_pc = 16'h0010; s_br = 2'd2; s_bra = 32'h0000_1230; fire("R10");
        clr(); s_pchk = 1; s_pc = 16'h0010; s_br = 2'd3; fire("R10");
        // R11: illegal subject, merged cause, no effect outside subject
        clr(); s_xf = 1; s_br = 2'd2; s_bra = 32'h0000_0ABC; fire("R11");
        clr(); s_xf = 1; s_br = 2'd2; s_pchk = 1; s_pc = 16'h0020; fire("R11");
        clr(); s_xf = 1; s_br = 2'd0; fire("R11");
        // R12: interrupt gives no exception strobe
        clr(); s_req = 7'b1000000; fire("R12");
        idle(4);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule